// File: doc/BRIEF.md
# EEPROM Page Write Engine

A synchronous model of the write path of a byte-wide parallel EEPROM that has a page buffer. A client issues write strobes, each carrying an address and a data byte. The first accepted write opens a page. Later writes to the same page add bytes to a buffer that holds up to 128 entries. Every accepted write restarts a byte-load window. When that window runs out with no new write, the engine enters an internal programming phase of fixed length. At the end of that phase it commits every buffered byte to the array in a single cycle.

While the programming phase runs, a read of the most recently loaded address returns that byte with its most significant bit inverted. This lets a client poll for completion. Reads of any other address, and all reads made while bytes are still being loaded, return the array contents. The busy flag is high from the first accepted write until the commit. Writes that fall outside the open page, and writes made during programming, are dropped.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, busy and rdValid are 0 and every array byte reads as 0x00.
- R2: A read request taken on a clock edge sets rdValid and rdData on that same edge, so both are visible in the following cycle. Outside the polling case of R8, rdData equals the array byte at rdAddr.
- R3: A write strobe while busy is 0 is accepted and busy is 1 from the next cycle. The page number is address bits [ADDR_W-1:7] and the byte offset within the page is bits [6:0].
- R4: The load window is retriggerable. Programming starts only after LOAD_WIN consecutive cycles without an accepted write, and each accepted write restarts the count from zero.
- R5: Programming lasts PROG_CYC cycles whatever the number of loaded bytes. Busy falls exactly LOAD_WIN+PROG_CYC cycles after the last accepted write.
- R6: Up to 128 bytes of one page can be loaded. All of them are written to the array on the same edge that ends programming, and later reads return them.
- R7: Bytes of the page that were not loaded in this cycle keep their previous array contents.
- R8: During programming, a read of the address of the last loaded byte returns that byte with bit 7 inverted. During loading, reads return the old array value. After the commit, the true value is returned.
- R9: During loading, a write whose page number differs from the open page is ignored: nothing is stored and the window is not restarted.
- R10: Writes made during programming are ignored: nothing is stored and the phase length is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| wrStb | input | 1 | Qualified write strobe, one cycle per byte |
| wrAddr | input | ADDR_W | Byte address of the write |
| wrData | input | 8 | Byte to write |
| rdReq | input | 1 | Read request |
| rdAddr | input | ADDR_W | Byte address of the read |
| rdData | output | 8 | Read result, valid while rdValid is 1 |
| rdValid | output | 1 | One-cycle flag marking rdData as valid |
| busy | output | 1 | High from the first accepted write until the commit |

## Verification
The hardest situations to reach are the ones that depend on where a strobe lands relative to the two internal counters. Examples are a write that arrives one cycle before the load window would close, and a read or write that arrives inside the programming phase. The bench reaches them by counting falling edges from the return of a write. A write takes effect on a known edge and the window and phase lengths are parameters, so a fixed wait puts the next stimulus in a chosen phase. The bench then checks the exact cycle on which busy falls, which shows whether the window was restarted or left unchanged.

// File: rtl/eeprom_pw_pkg.sv
package eeprom_pw_pkg;

  typedef enum logic [1:0] {
    PW_IDLE,
    PW_LOAD,
    PW_PROG
  } pwState_t;

  typedef struct packed {
    logic loadByte;   // store wrData into the page buffer
    logic startPage;  // latch a new page number, clear the loaded mask
    logic commit;     // copy loaded bytes into the array
    logic pollEn;     // programming in progress: polling reads active
  } pwStrobe_t;

endpackage

// File: rtl/eeprom_pw_ctrl.sv
module eeprom_pw_ctrl
  import eeprom_pw_pkg::*;
#(
  parameter int LOAD_WIN = 16,
  parameter int PROG_CYC = 40
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrStb,
  input  logic      pageMatch,
  output pwStrobe_t stb,
  output logic      busy,
  output logic      progPhase
);

  localparam int LW = $clog2(LOAD_WIN + 1);
  localparam int PW = $clog2(PROG_CYC + 1);
  localparam logic [LW-1:0] LOAD_LAST = LW'(LOAD_WIN - 1);
  localparam logic [PW-1:0] PROG_LAST = PW'(PROG_CYC - 1);

  pwState_t      state, stateNxt;
  logic [LW-1:0] loadCnt;
  logic [PW-1:0] progCnt;

  always_comb begin
    stb      = '0;
    stateNxt = state;
    unique case (state)
      PW_IDLE: begin
        if (wrStb) begin
          stb.loadByte  = 1'b1;
          stb.startPage = 1'b1;
          stateNxt      = PW_LOAD;
        end
      end
      PW_LOAD: begin
        if (wrStb && pageMatch) begin
          stb.loadByte = 1'b1;
        end else if (loadCnt == LOAD_LAST) begin
          stateNxt = PW_PROG;
        end
      end
      PW_PROG: begin
        stb.pollEn = 1'b1;
        if (progCnt == PROG_LAST) begin
          stb.commit = 1'b1;
          stateNxt   = PW_IDLE;
        end
      end
      default: stateNxt = PW_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= PW_IDLE;
      loadCnt <= '0;
      progCnt <= '0;
    end else begin
      state <= stateNxt;
      if (stb.loadByte) begin
        loadCnt <= '0;
      end else if (state == PW_LOAD) begin
        loadCnt <= loadCnt + 1'b1;
      end
      if (state == PW_PROG && !stb.commit) begin
        progCnt <= progCnt + 1'b1;
      end else begin
        progCnt <= '0;
      end
    end
  end

  assign busy      = (state != PW_IDLE);
  assign progPhase = (state == PW_PROG);

endmodule

// File: rtl/eeprom_pw_datapath.sv
module eeprom_pw_datapath
  import eeprom_pw_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int OFF_W  = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwStrobe_t         stb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdReq,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              pageMatch,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  localparam int PAGE_BYTES = 1 << OFF_W;
  localparam int PAGE_W     = ADDR_W - OFF_W;
  localparam int DEPTH      = 1 << ADDR_W;
  localparam logic [DATA_W-1:0] POLL_MASK = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0]     mem     [DEPTH];
  logic [DATA_W-1:0]     pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pageVld;
  logic [PAGE_W-1:0]     pageReg;
  logic [OFF_W-1:0]      lastOff;

  logic [PAGE_W-1:0]     wrPage;
  logic [OFF_W-1:0]      wrOff;
  logic [PAGE_BYTES-1:0] offHot;
  logic                  pollHit;

  assign wrPage    = wrAddr[ADDR_W-1:OFF_W];
  assign wrOff     = wrAddr[OFF_W-1:0];
  assign offHot    = {{(PAGE_BYTES-1){1'b0}}, 1'b1} << wrOff;
  assign pageMatch = (wrPage == pageReg);
  assign pollHit   = stb.pollEn && (rdAddr == {pageReg, lastOff});

  // page buffer and load bookkeeping
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageReg <= '0;
      lastOff <= '0;
      pageVld <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) pageBuf[i] <= '0;
    end else if (stb.loadByte) begin
      pageBuf[wrOff] <= wrData;
      lastOff        <= wrOff;
      if (stb.startPage) begin
        pageReg <= wrPage;
        pageVld <= offHot;
      end else begin
        pageVld <= pageVld | offHot;
      end
    end
  end

  // array: whole-page commit and registered read port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      if (stb.commit) begin
        for (int i = 0; i < PAGE_BYTES; i++) begin
          if (pageVld[i]) mem[{pageReg, OFF_W'(i)}] <= pageBuf[i];
        end
      end
      rdValid <= rdReq;
      if (rdReq) begin
        rdData <= pollHit ? (pageBuf[lastOff] ^ POLL_MASK) : mem[rdAddr];
      end
    end
  end

endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import eeprom_pw_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int OFF_W    = 7,
  parameter int LOAD_WIN = 16,
  parameter int PROG_CYC = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              rdReq,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic              rdValid,
  output logic              busy
);

  pwStrobe_t ctrlStb;
  logic      pageMatch;
  logic      progPhase;

  eeprom_pw_ctrl #(
    .LOAD_WIN(LOAD_WIN),
    .PROG_CYC(PROG_CYC)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrStb    (wrStb),
    .pageMatch(pageMatch),
    .stb      (ctrlStb),
    .busy     (busy),
    .progPhase(progPhase)
  );

  eeprom_pw_datapath #(
    .ADDR_W(ADDR_W),
    .OFF_W (OFF_W),
    .DATA_W(8)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (ctrlStb),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .rdReq    (rdReq),
    .rdAddr   (rdAddr),
    .pageMatch(pageMatch),
    .rdData   (rdData),
    .rdValid  (rdValid)
  );

endmodule

// File: rtl/eeprom_page_writer_chk.sv
module eeprom_page_writer_chk #(
  parameter int LOAD_WIN = 16,
  parameter int PROG_CYC = 40
) (
  input logic clk,
  input logic rstN,
  input logic wrStb,
  input logic rdReq,
  input logic rdValid,
  input logic busy,
  input logic progPhase,
  input logic loadStb,
  input logic commitStb
);

  int quietCnt;
  int progCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quietCnt <= 0;
      progCnt  <= 0;
    end else begin
      if (loadStb) quietCnt <= 0;
      else if (quietCnt <= LOAD_WIN) quietCnt <= quietCnt + 1;
      if (!progPhase) progCnt <= 0;
      else progCnt <= progCnt + 1;
    end
  end

  // R2
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> rdValid);

  // R3
  idle_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && wrStb) |=> busy);

  // R4
  quiet_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(progPhase) |-> (quietCnt == LOAD_WIN));

  // R5
  prog_length_chk: assert property (@(posedge clk) disable iff (!rstN)
    commitStb |-> (progCnt == PROG_CYC - 1));

  // R6
  commit_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    commitStb |=> !busy);

  // R10
  no_load_in_prog_chk: assert property (@(posedge clk) disable iff (!rstN)
    progPhase |-> !loadStb);

endmodule

bind eeprom_page_writer eeprom_page_writer_chk #(
  .LOAD_WIN(LOAD_WIN),
  .PROG_CYC(PROG_CYC)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrStb    (wrStb),
  .rdReq    (rdReq),
  .rdValid  (rdValid),
  .busy     (busy),
  .progPhase(progPhase),
  .loadStb  (ctrlStb.loadByte),
  .commitStb(ctrlStb.commit)
);

// File: tb/eeprom_page_writer_tb.sv
module eeprom_page_writer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 10;
  localparam int LOAD_WIN   = 16;
  localparam int PROG_CYC   = 40;
  localparam int NVEC       = 6;
  // each entry: {address[9:0], data[7:0]}
  localparam logic [17:0] VECS [NVEC] = '{
    {10'h005, 8'h3C}, {10'h07F, 8'hFF}, {10'h080, 8'h01},
    {10'h3FF, 8'hA5}, {10'h200, 8'h80}, {10'h005, 8'h7E}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrStb = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [7:0]        wrData = '0;
  logic              rdReq = 1'b0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [7:0]        rdData;
  logic              rdValid;
  logic              busy;

  int  tests = 0;
  int  fails = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  eeprom_page_writer #(
    .ADDR_W  (ADDR_W),
    .OFF_W   (7),
    .LOAD_WIN(LOAD_WIN),
    .PROG_CYC(PROG_CYC)
  ) u_dut (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .wrAddr(wrAddr), .wrData(wrData),
    .rdReq(rdReq), .rdAddr(rdAddr), .rdData(rdData), .rdValid(rdValid), .busy(busy)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic doWrite(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    wrStb = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrStb = 1'b0;
  endtask

  task automatic doRead(input logic [ADDR_W-1:0] a, output logic [7:0] d, output logic v);
    rdReq = 1'b1; rdAddr = a;
    @(negedge clk);
    rdReq = 1'b0;
    d = rdData; v = rdValid;
  endtask

  task automatic waitIdle(output int n);
    n = 0;
    while (busy && n < 100000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R5 watchdog expired actual=busy expected=idle");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic       v;
    int         n;
    int         bad;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1", "busy after reset", int'(busy), 0);
    check("R1", "rdValid after reset", int'(rdValid), 0);
    doRead(10'h123, d, v);
    check("R1", "array byte after reset", int'(d), 0);
    check("R2", "rdValid after read", int'(v), 1);

    // table walk: single-byte pages, R3 R5 R6
    for (int k = 0; k < NVEC; k++) begin
      doWrite(VECS[k][17:8], VECS[k][7:0]);
      check("R3", "busy after idle write", int'(busy), 1);
      waitIdle(n);
      check("R5", "busy length single byte", n, LOAD_WIN + PROG_CYC);
      doRead(VECS[k][17:8], d, v);
      check("R6", "readback table entry", int'(d), int'(VECS[k][7:0]));
    end

    // R6 full 128-byte page (page 2), back-to-back loads
    for (int i = 0; i < 128; i++) doWrite(10'h100 + 10'(i), 8'(i) ^ 8'h5A);
    check("R4", "busy during page load", int'(busy), 1);
    waitIdle(n);
    check("R5", "busy length full page", n, LOAD_WIN + PROG_CYC);
    bad = 0;
    for (int i = 0; i < 128; i++) begin
      doRead(10'h100 + 10'(i), d, v);
      if (d != (8'(i) ^ 8'h5A)) bad++;
    end
    check("R6", "full page mismatches", bad, 0);

    // R7 partial reload of page 2
    doWrite(10'h10A, 8'hEE);
    waitIdle(n);
    doRead(10'h10A, d, v);
    check("R7", "reloaded byte", int'(d), 'hEE);
    doRead(10'h109, d, v);
    check("R7", "unloaded neighbour below", int'(d), 'h09 ^ 'h5A);
    doRead(10'h10B, d, v);
    check("R7", "unloaded neighbour above", int'(d), 'h0B ^ 'h5A);

    // R4 retrigger one cycle before the window would close
    doWrite(10'h181, 8'h11);
    repeat (LOAD_WIN - 2) @(negedge clk);
    doWrite(10'h182, 8'h22);
    waitIdle(n);
    check("R4", "window restarted by late write", n, LOAD_WIN + PROG_CYC);
    doRead(10'h181, d, v);
    check("R4", "first byte of retriggered page", int'(d), 'h11);
    doRead(10'h182, d, v);
    check("R4", "second byte of retriggered page", int'(d), 'h22);

    // R8 polling and R10 write during programming
    doWrite(10'h1C3, 8'h42);
    doRead(10'h1C3, d, v);
    check("R8", "read during load returns old", int'(d), 0);
    repeat (LOAD_WIN - 1) @(negedge clk);
    doRead(10'h1C3, d, v);
    check("R8", "poll last byte bit7 inverted", int'(d), 'hC2);
    doRead(10'h1C4, d, v);
    check("R8", "other address during prog", int'(d), 0);
    doWrite(10'h1C5, 8'h77);
    waitIdle(n);
    check("R10", "prog length unchanged by write", n, PROG_CYC - 3);
    doRead(10'h1C3, d, v);
    check("R8", "true data after commit", int'(d), 'h42);
    doRead(10'h1C5, d, v);
    check("R10", "write during prog not stored", int'(d), 0);

    // R8 only the last loaded byte is polled
    doWrite(10'h303, 8'h10);
    doWrite(10'h307, 8'h20);
    repeat (LOAD_WIN) @(negedge clk);
    doRead(10'h307, d, v);
    check("R8", "poll last of two bytes", int'(d), 'hA0);
    doRead(10'h303, d, v);
    check("R8", "earlier byte not polled", int'(d), 0);
    waitIdle(n);
    doRead(10'h303, d, v);
    check("R6", "earlier byte committed", int'(d), 'h10);

    // R9 write to another page during load
    doWrite(10'h205, 8'h99);
    doWrite(10'h285, 8'h66);
    waitIdle(n);
    check("R9", "foreign-page write no retrigger", n, LOAD_WIN + PROG_CYC - 1);
    doRead(10'h285, d, v);
    check("R9", "foreign-page byte not stored", int'(d), 0);
    doRead(10'h205, d, v);
    check("R9", "open-page byte stored", int'(d), 'h99);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule